// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by combining two direction predictors. The first is a per-address table of 2-bit saturating counters. The second is a table of 2-bit counters addressed by the recent pattern of resolved branch outcomes (a global history register). A third table of 2-bit counters, addressed by the branch address, acts as a chooser. For each branch it decides which of the two component predictions is passed on as the final answer. The address-indexed component learns quickly, so it covers branches while the history-indexed component is still warming up. The chooser then moves to the history-indexed component for branches where that component proves more accurate.

A lookup request carries the branch's index bits and returns three things in the same cycle: the final prediction, both component predictions, and the history value used for the lookup. The front end keeps these with the branch. When the branch resolves, it returns them on the update stream together with the actual outcome. A context-switch flush clears every table one row per cycle. While the flush runs, the block reports busy, refuses both streams and predicts not-taken.

Both the lookup and the update side are valid/ready streams. A transfer happens in a cycle where valid and ready are both high. While ready is low, the sender holds its request and may keep valid asserted. Ready is low only during a flush, and on the update side also in the cycle a flush is requested. Nothing is queued inside the block.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every counter in all three tables holds 01 (weakly not-taken, and for the chooser weakly favouring the address-indexed component) and the history register is zero. Every lookup therefore returns final, address-indexed and history-indexed predictions of 0.
- R2: The address-indexed component is a table of 2^IDX_W 2-bit counters selected by `pq_pc_i`. Its prediction is the counter's upper bit. Every accepted update moves the counter at `up_pc_i` by +1 when taken and by -1 when not taken, saturating at 00 and 11.
- R3: The history-indexed component is a table of 2^HIST_W 2-bit counters. A lookup reads the entry selected by the current history register. An accepted update trains the entry selected by `up_hist_i` with the same saturating rule as R2.
- R4: Each accepted update shifts the history register left by one and places the outcome in bit 0 (1 = taken). `pr_hist_o` shows the current history value.
- R5: The chooser table is selected by `pq_pc_i`. When the chooser counter's upper bit is 1, the final prediction is the history-indexed prediction; when it is 0, the final prediction is the address-indexed prediction.
- R6: The chooser counter at `up_pc_i` changes only when `up_bim_i` and `up_glb_i` differ. It steps +1 when `up_glb_i` equals the outcome and -1 otherwise, saturating. Both components train on every accepted update regardless of which one was chosen.
- R7: A flush is accepted when `flush_i` is high and the block is not busy. `busy_o` then rises after that edge and stays high for exactly 2^max(IDX_W,HIST_W) cycles. When it falls, all tables and the history register are back in the R1 state.
- R8: While busy, `pq_ready_o` and `up_ready_o` are low, all three prediction outputs are 0, and an update presented on the update stream has no effect.
- R9: `pq_ready_o` is the inverse of busy, and `up_ready_o` is low while busy or while `flush_i` is high. The prediction outputs are 0 unless a lookup is transferred in that cycle. An update changes state at the edge where it is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Context-switch request to clear all tables |
| busy_o | output | 1 | Flush in progress |
| pq_valid_i | input | 1 | Lookup request valid |
| pq_ready_o | output | 1 | Lookup request accepted |
| pq_pc_i | input | IDX_W | Branch address bits of the lookup |
| pr_taken_o | output | 1 | Final prediction (1 = taken) |
| pr_bim_o | output | 1 | Address-indexed component prediction |
| pr_glb_o | output | 1 | History-indexed component prediction |
| pr_hist_o | output | HIST_W | History value used by this lookup |
| up_valid_i | input | 1 | Resolved-branch update valid |
| up_ready_o | output | 1 | Update accepted |
| up_pc_i | input | IDX_W | Branch address bits of the resolved branch |
| up_hist_i | input | HIST_W | History value saved at lookup |
| up_taken_i | input | 1 | Resolved outcome (1 = taken) |
| up_bim_i | input | 1 | Saved address-indexed prediction |
| up_glb_i | input | 1 | Saved history-indexed prediction |

## Verification
Some properties are checked by assertions on every cycle. Counters hold their value unless they are written, and they saturate at both ends. The history shifts in the outcome of each accepted update and stays frozen while busy. The flush sequencer starts when a flush is requested and ends on its last row. The streams are closed and all predictions are zero during a flush. Other behaviours can only be shown by the bench's scenarios: the actual prediction values, the chooser moving only on disagreement, and the complete return to the reset state after a flush. The bench runs a reference model through an all-address saturation sweep, a looping outcome pattern and a long pseudo-random sequence, and compares every lookup against that model.

// File: rtl/tournament_bp_pkg.sv
package tournament_bp_pkg;
  typedef logic [1:0] ctr2_t;
  localparam ctr2_t CTR_INIT = 2'b01;

  function automatic ctr2_t sat_step(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tournament_bp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_msb,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_idx,
  input  logic          upd_up,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx
);
  localparam int DEPTH = 1 << AW;

  ctr2_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (clr_en) begin
      mem[clr_idx] <= CTR_INIT;
    end else if (upd_en) begin
      mem[upd_idx] <= sat_step(mem[upd_idx], upd_up);
    end
  end

  assign rd_msb = mem[rd_idx][1];

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !((clr_en && clr_idx == AW'(g)) || (upd_en && upd_idx == AW'(g)))
      |=> $stable(mem[g]));
  end

  a_r2_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en && upd_up && mem[upd_idx] == 2'b11)
    |=> mem[$past(upd_idx)] == 2'b11);

  a_r2_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en && !upd_up && mem[upd_idx] == 2'b00)
    |=> mem[$past(upd_idx)] == 2'b00);
endmodule

// File: rtl/tbp_hist_reg.sv
module tbp_hist_reg #(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HW-1:0] hist_o
);
  logic [HW-1:0] hist_q;
  logic [HW:0]   shifted;

  assign shifted = {hist_q, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (clr)      hist_q <= '0;
    else if (shift_en) hist_q <= shifted[HW-1:0];
  end

  assign hist_o = hist_q;

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> hist_o[0] == $past(bit_in));
endmodule

// File: rtl/tbp_flush_seq.sv
module tbp_flush_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  output logic          start_o,
  output logic          busy_o,
  output logic [CW-1:0] row_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign start_o = flush_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == {CW{1'b1}}) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign row_o  = cnt_q;

  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !busy_o) |=> (busy_o && row_o == '0));

  a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && row_o == {CW{1'b1}}) |=> !busy_o);
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import tournament_bp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  output logic              busy_o,
  input  logic              pq_valid_i,
  output logic              pq_ready_o,
  input  logic [IDX_W-1:0]  pq_pc_i,
  output logic              pr_taken_o,
  output logic              pr_bim_o,
  output logic              pr_glb_o,
  output logic [HIST_W-1:0] pr_hist_o,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  input  logic [IDX_W-1:0]  up_pc_i,
  input  logic [HIST_W-1:0] up_hist_i,
  input  logic              up_taken_i,
  input  logic              up_bim_i,
  input  logic              up_glb_i
);
  localparam int ROW_W = (IDX_W > HIST_W) ? IDX_W : HIST_W;

  logic             busy, flush_start, up_fire, pq_fire;
  logic [ROW_W-1:0] row;
  logic [HIST_W-1:0] hist;
  logic             bim_msb, glb_msb, sel_msb, sel_upd;

  tbp_flush_seq #(.CW(ROW_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .start_o(flush_start), .busy_o(busy), .row_o(row)
  );

  assign pq_ready_o = !busy;
  assign up_ready_o = !busy && !flush_i;
  assign pq_fire    = pq_valid_i && pq_ready_o;
  assign up_fire    = up_valid_i && up_ready_o;
  assign sel_upd    = up_fire && (up_bim_i != up_glb_i);

  tbp_hist_reg #(.HW(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(flush_start),
    .shift_en(up_fire), .bit_in(up_taken_i), .hist_o(hist)
  );

  tbp_ctr_table #(.AW(IDX_W)) u_bim (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pq_pc_i), .rd_msb(bim_msb),
    .upd_en(up_fire), .upd_idx(up_pc_i), .upd_up(up_taken_i),
    .clr_en(busy), .clr_idx(row[IDX_W-1:0])
  );

  tbp_ctr_table #(.AW(HIST_W)) u_glb (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(hist), .rd_msb(glb_msb),
    .upd_en(up_fire), .upd_idx(up_hist_i), .upd_up(up_taken_i),
    .clr_en(busy), .clr_idx(row[HIST_W-1:0])
  );

  tbp_ctr_table #(.AW(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pq_pc_i), .rd_msb(sel_msb),
    .upd_en(sel_upd), .upd_idx(up_pc_i), .upd_up(up_glb_i == up_taken_i),
    .clr_en(busy), .clr_idx(row[IDX_W-1:0])
  );

  assign busy_o     = busy;
  assign pr_hist_o  = hist;
  assign pr_bim_o   = pq_fire && bim_msb;
  assign pr_glb_o   = pq_fire && glb_msb;
  assign pr_taken_o = pq_fire && (sel_msb ? glb_msb : bim_msb);

  a_r8_closed: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!pq_ready_o && !up_ready_o && !pr_taken_o && !pr_bim_o && !pr_glb_o));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(pr_hist_o));

  a_r5_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_bim_o == pr_glb_o) |-> (pr_taken_o == pr_bim_o));
endmodule

// File: tb/tournament_bp_tb.sv
module tournament_bp_tb;
  localparam int IW = 4, HW = 4, ROWS = 16, NI = 1 << IW, NH = 1 << HW;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic flush_i = 0, busy_o;
  logic pq_valid_i = 0, pq_ready_o;
  logic [IW-1:0] pq_pc_i = '0;
  logic pr_taken_o, pr_bim_o, pr_glb_o;
  logic [HW-1:0] pr_hist_o;
  logic up_valid_i = 0, up_ready_o;
  logic [IW-1:0] up_pc_i = '0;
  logic [HW-1:0] up_hist_i = '0;
  logic up_taken_i = 0, up_bim_i = 0, up_glb_i = 0;

  tournament_bp #(.IDX_W(IW), .HIST_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .busy_o(busy_o),
    .pq_valid_i(pq_valid_i), .pq_ready_o(pq_ready_o), .pq_pc_i(pq_pc_i),
    .pr_taken_o(pr_taken_o), .pr_bim_o(pr_bim_o), .pr_glb_o(pr_glb_o),
    .pr_hist_o(pr_hist_o), .up_valid_i(up_valid_i), .up_ready_o(up_ready_o),
    .up_pc_i(up_pc_i), .up_hist_i(up_hist_i), .up_taken_i(up_taken_i),
    .up_bim_i(up_bim_i), .up_glb_i(up_glb_i)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] bim_m [NI];
  logic [1:0] glb_m [NH];
  logic [1:0] sel_m [NI];
  logic [HW-1:0] hist_m;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sat2(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin bim_m[i] = 2'b01; sel_m[i] = 2'b01; end
    for (int i = 0; i < NH; i++) glb_m[i] = 2'b01;
    hist_m = '0;
  endtask

  // one lookup followed by the matching update in the same cycle
  task automatic step(input logic [IW-1:0] pc, input logic tk);
    logic eb, eg, et;
    @(negedge clk);
    pq_valid_i = 1; pq_pc_i = pc;
    #1;
    eb = bim_m[pc][1];
    eg = glb_m[hist_m][1];
    et = sel_m[pc][1] ? eg : eb;
    chk(pr_bim_o == eb, "R2", "bimodal prediction", pr_bim_o, eb);
    chk(pr_glb_o == eg, "R3", "global prediction", pr_glb_o, eg);
    chk(pr_hist_o == hist_m, "R4", "history", pr_hist_o, hist_m);
    chk(pr_taken_o == et, "R5 R6", "final prediction", pr_taken_o, et);
    chk(up_ready_o && pq_ready_o, "R9", "ready while idle", up_ready_o, 1);
    up_valid_i = 1; up_pc_i = pc; up_hist_i = pr_hist_o; up_taken_i = tk;
    up_bim_i = pr_bim_o; up_glb_i = pr_glb_o;
    @(posedge clk);
    bim_m[pc] = sat2(bim_m[pc], tk);
    glb_m[hist_m] = sat2(glb_m[hist_m], tk);
    if (eb != eg) sel_m[pc] = sat2(sel_m[pc], eg == tk);
    hist_m = {hist_m[HW-2:0], tk};
    #1;
    up_valid_i = 0; pq_valid_i = 0;
  endtask

  task automatic check_reset_state(input string req);
    for (int p = 0; p < NI; p++) begin
      @(negedge clk);
      pq_valid_i = 1; pq_pc_i = p[IW-1:0];
      #1;
      chk(!pr_taken_o && !pr_bim_o && !pr_glb_o, req, "initial predictions zero",
          {pr_taken_o, pr_bim_o, pr_glb_o}, 0);
    end
    chk(pr_hist_o == '0, req, "history zero", pr_hist_o, 0);
    chk(!busy_o, req, "not busy", busy_o, 0);
    pq_valid_i = 0;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check_reset_state("R1");

    // R2 saturation sweep: every address driven to both ends
    for (int p = 0; p < NI; p++) for (int k = 0; k < 4; k++) step(p[IW-1:0], 1'b1);
    for (int p = 0; p < NI; p++) for (int k = 0; k < 5; k++) step(p[IW-1:0], 1'b0);

    // looping pattern: history correlated outcomes (R3 R6)
    for (int i = 0; i < 300; i++) step(IW'(i % 3), (i % 5) != 4);

    // pseudo-random mix
    lf = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[IW-1:0], lf[6] ^ lf[2]);
    end

    // R9 outputs zero without a valid lookup
    for (int p = 0; p < NI; p++) begin
      @(negedge clk);
      pq_valid_i = 0; pq_pc_i = p[IW-1:0];
      #1;
      chk(!pr_taken_o && !pr_bim_o && !pr_glb_o, "R9", "no lookup no prediction",
          {pr_taken_o, pr_bim_o, pr_glb_o}, 0);
    end

    // R7 flush with R8 ignored updates
    @(negedge clk);
    flush_i = 1;
    #1 chk(!up_ready_o, "R9", "update ready low on flush request", up_ready_o, 0);
    @(negedge clk);
    flush_i = 0;
    for (int k = 0; k < ROWS; k++) begin
      pq_valid_i = 1; pq_pc_i = IW'(k);
      up_valid_i = 1; up_pc_i = IW'(k); up_taken_i = 1; up_hist_i = IW'(k);
      up_bim_i = 0; up_glb_i = 1;
      #1;
      chk(busy_o, "R7", "busy during flush", busy_o, 1);
      chk(!pq_ready_o && !up_ready_o, "R8", "streams closed", {pq_ready_o, up_ready_o}, 0);
      chk(!pr_taken_o && !pr_bim_o && !pr_glb_o, "R8", "not-taken during flush",
          {pr_taken_o, pr_bim_o, pr_glb_o}, 0);
      @(negedge clk);
    end
    up_valid_i = 0; pq_valid_i = 0;
    #1 chk(!busy_o, "R7", "busy falls after all rows", busy_o, 0);
    model_reset();
    check_reset_state("R7");

    // training resumes normally after flush (R8 updates had no effect)
    for (int i = 0; i < 40; i++) step(IW'(i % 4), i[1]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule